// File: doc/BRIEF.md
# Interrupt acknowledge cycle sequencer

This block sits on the processor side of an interrupt path. It turns a pending interrupt level into one acknowledge bus cycle and returns the vector number that exception dispatch uses. When a nonzero level is pending, the sequencer captures that level and waits for the instruction-boundary strobe. It then asks the stacking logic to save processor state for a fixed number of cycles. In the last of those cycles it pulses a status update that sets the supervisor bit and clears both trace bits. After that it runs the acknowledge cycle in the CPU address space. In that cycle the address carries the captured level, and the sequencer waits for the bus to end the cycle.

The bus can end the cycle in three ways: a supplied vector with acknowledge, an autovector request, or a bus error. The bus error is handled as a spurious interrupt. The sequencer turns the termination into a vector number and reports it with a one-cycle done pulse. It then returns to idle. Instruction execution and the memory writes of stacking belong to other blocks.

The states are IDLE, WAIT_BOUNDARY, STACK, IACK_DRIVE, IACK_WAIT and DONE. The transitions are:
- IDLE to WAIT_BOUNDARY when the pending level is nonzero. The level is captured on this transition.
- WAIT_BOUNDARY to STACK on the boundary strobe.
- STACK to IACK_DRIVE after STACK_CYCLES cycles.
- IACK_DRIVE to IACK_WAIT unconditionally.
- IACK_WAIT to DONE on any termination.
- DONE to IDLE unconditionally.

Top module: `iack_sequencer`

## Requirements
- R1: After reset, stack_req, sr_enter_super, bus_cycle, fc, addr, done, done_vector and done_kind are all zero.
- R2: A pending level of 0 never starts a sequence: boundary strobes have no effect and stack_req and bus_cycle stay low.
- R3: With a nonzero level pending, stack_req stays low until boundary is sampled high. From the next cycle it is high for exactly STACK_CYCLES cycles (default 4).
- R4: sr_enter_super (set supervisor, clear T1 and T0) is a one-cycle pulse in the last stack_req cycle, before any bus cycle.
- R5: In the cycle after stacking ends, bus_cycle rises. While it is high, fc is 3'b111 and addr has bits 23:4 all ones, bits 3:1 equal to the level and bit 0 set. Outside the bus cycle, fc and addr are zero.
- R6: The level is captured when the sequence leaves IDLE. Later changes on pend_level do not change addr for the rest of the sequence.
- R7: Bus responses are sampled only in IACK_WAIT, the second and later bus_cycle cycles. A response in the first bus_cycle cycle is ignored.
- R8: A vector termination (resp_vec_valid) gives done_kind 2'b01 and done_vector equal to resp_vec.
- R9: An autovector termination gives done_kind 2'b10 and done_vector 24 plus the level.
- R10: A bus error termination gives done_kind 2'b11 and the spurious vector, 24.
- R11: When several responses arrive together, bus error wins over autovector, and autovector wins over the supplied vector.
- R12: done is high for exactly one cycle, the cycle after the termination is sampled, and the block then returns to idle. done_kind is 2'b00 whenever done is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pend_level | input | 3 | Pending interrupt level, 0 means none |
| boundary | input | 1 | Instruction boundary / exception handling finished strobe |
| resp_vec_valid | input | 1 | Bus supplies a vector and acknowledges |
| resp_vec | input | 8 | Vector number supplied by the bus |
| resp_autovec | input | 1 | Bus requests an autovector |
| resp_buserr | input | 1 | Bus error termination |
| stack_req | output | 1 | Request to stack processor state |
| sr_enter_super | output | 1 | Pulse: set supervisor bit, clear T1 and T0 |
| bus_cycle | output | 1 | Acknowledge bus cycle in progress |
| fc | output | 3 | Function code, 3'b111 during the cycle |
| addr | output | 24 | Acknowledge address |
| done | output | 1 | One-cycle completion pulse |
| done_vector | output | 8 | Vector number for dispatch |
| done_kind | output | 2 | 01 vector, 10 autovector, 11 bus error, 00 idle |

## Verification
If boundary is sampled at edge k, stack_req is high in cycles k+1 to k+STACK_CYCLES, and sr_enter_super is high only in the last of these. bus_cycle with the address follows at k+STACK_CYCLES+1, and responses count from k+STACK_CYCLES+2. done with the vector appears one cycle after the sampled response and clears in the cycle after that. The bench drives inputs and reads outputs on the falling edge. It steps through these cycles one at a time, so every check lands on the exact cycle where a result is due and is also checked to be absent in the cycles around it.

// File: rtl/iack_pkg.sv
package iack_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_BOUNDARY,
        ST_STACK,
        ST_IACK_DRIVE,
        ST_IACK_WAIT,
        ST_DONE
    } iack_state_e;

    typedef enum logic [1:0] {
        TERM_NONE   = 2'b00,
        TERM_VECTOR = 2'b01,
        TERM_AUTO   = 2'b10,
        TERM_BUSERR = 2'b11
    } iack_term_e;

    localparam int FC_W = 3;
    localparam logic [FC_W-1:0] FC_CPU_SPACE = 3'b111;

endpackage

// File: rtl/iack_stack_timer.sv
module iack_stack_timer #(
    parameter int STACK_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic run,
    output logic last
);
    localparam int CNT_W = (STACK_CYCLES < 2) ? 1 : $clog2(STACK_CYCLES);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(STACK_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= '0;
        end else if (run && !last) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign last = run && (cnt_q == LAST_CNT);

endmodule

// File: rtl/iack_addr_gen.sv
module iack_addr_gen #(
    parameter int ADDR_W = 24,
    parameter int LVL_W  = 3
) (
    input  logic [LVL_W-1:0]  level,
    output logic [ADDR_W-1:0] ack_addr
);
    localparam int HI_W = ADDR_W - LVL_W - 1;

    generate
        if (HI_W > 0) begin : g_hi
            assign ack_addr = {{HI_W{1'b1}}, level, 1'b1};
        end else begin : g_nohi
            assign ack_addr = ADDR_W'({level, 1'b1});
        end
    endgenerate

endmodule

// File: rtl/iack_term_map.sv
module iack_term_map
    import iack_pkg::*;
#(
    parameter int LVL_W        = 3,
    parameter int VEC_W        = 8,
    parameter int AUTOVEC_BASE = 24,
    parameter int SPURIOUS_VEC = 24
) (
    input  logic [LVL_W-1:0] level,
    input  logic             resp_vec_valid,
    input  logic [VEC_W-1:0] resp_vec,
    input  logic             resp_autovec,
    input  logic             resp_buserr,
    output logic             term_hit,
    output iack_term_e       term_kind,
    output logic [VEC_W-1:0] term_vector
);
    localparam logic [VEC_W-1:0] AUTO_BASE_V = VEC_W'(AUTOVEC_BASE);
    localparam logic [VEC_W-1:0] SPUR_V      = VEC_W'(SPURIOUS_VEC);

    assign term_hit = resp_buserr | resp_autovec | resp_vec_valid;

    always_comb begin
        term_kind   = TERM_NONE;
        term_vector = '0;
        if (resp_buserr) begin
            term_kind   = TERM_BUSERR;
            term_vector = SPUR_V;
        end else if (resp_autovec) begin
            term_kind   = TERM_AUTO;
            term_vector = AUTO_BASE_V + VEC_W'(level);
        end else if (resp_vec_valid) begin
            term_kind   = TERM_VECTOR;
            term_vector = resp_vec;
        end
    end

endmodule

// File: rtl/iack_sequencer.sv
module iack_sequencer
    import iack_pkg::*;
#(
    parameter int ADDR_W       = 24,
    parameter int LVL_W        = 3,
    parameter int VEC_W        = 8,
    parameter int STACK_CYCLES = 4,
    parameter int AUTOVEC_BASE = 24,
    parameter int SPURIOUS_VEC = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LVL_W-1:0]  pend_level,
    input  logic              boundary,
    input  logic              resp_vec_valid,
    input  logic [VEC_W-1:0]  resp_vec,
    input  logic              resp_autovec,
    input  logic              resp_buserr,
    output logic              stack_req,
    output logic              sr_enter_super,
    output logic              bus_cycle,
    output logic [2:0]        fc,
    output logic [ADDR_W-1:0] addr,
    output logic              done,
    output logic [VEC_W-1:0]  done_vector,
    output logic [1:0]        done_kind
);
    iack_state_e      state_q, state_d;
    logic [LVL_W-1:0] level_q;
    iack_term_e       kind_q;
    logic [VEC_W-1:0] vec_q;

    logic              stack_last;
    logic [ADDR_W-1:0] ack_addr;
    logic              term_hit;
    iack_term_e        term_kind;
    logic [VEC_W-1:0]  term_vector;

    wire start_pend = (state_q == ST_IDLE) && (pend_level != '0);
    wire start_stk  = (state_q == ST_WAIT_BOUNDARY) && boundary;
    wire take_term  = (state_q == ST_IACK_WAIT) && term_hit;

    iack_stack_timer #(.STACK_CYCLES(STACK_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start_stk),
        .run   (state_q == ST_STACK),
        .last  (stack_last)
    );

    iack_addr_gen #(.ADDR_W(ADDR_W), .LVL_W(LVL_W)) u_addr (
        .level    (level_q),
        .ack_addr (ack_addr)
    );

    iack_term_map #(
        .LVL_W(LVL_W), .VEC_W(VEC_W),
        .AUTOVEC_BASE(AUTOVEC_BASE), .SPURIOUS_VEC(SPURIOUS_VEC)
    ) u_map (
        .level          (level_q),
        .resp_vec_valid (resp_vec_valid),
        .resp_vec       (resp_vec),
        .resp_autovec   (resp_autovec),
        .resp_buserr    (resp_buserr),
        .term_hit       (term_hit),
        .term_kind      (term_kind),
        .term_vector    (term_vector)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Captured level and termination result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= '0;
            kind_q  <= TERM_NONE;
            vec_q   <= '0;
        end else begin
            if (start_pend) begin
                level_q <= pend_level;
            end
            if (take_term) begin
                kind_q <= term_kind;
                vec_q  <= term_vector;
            end
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:          if (start_pend) state_d = ST_WAIT_BOUNDARY;
            ST_WAIT_BOUNDARY: if (start_stk)  state_d = ST_STACK;
            ST_STACK:         if (stack_last) state_d = ST_IACK_DRIVE;
            ST_IACK_DRIVE:    state_d = ST_IACK_WAIT;
            ST_IACK_WAIT:     if (take_term)  state_d = ST_DONE;
            ST_DONE:          state_d = ST_IDLE;
            default:          state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        stack_req      = 1'b0;
        sr_enter_super = 1'b0;
        bus_cycle      = 1'b0;
        fc             = '0;
        addr           = '0;
        done           = 1'b0;
        done_vector    = '0;
        done_kind      = TERM_NONE;
        unique case (state_q)
            ST_IDLE, ST_WAIT_BOUNDARY: ;
            ST_STACK: begin
                stack_req      = 1'b1;
                sr_enter_super = stack_last;
            end
            ST_IACK_DRIVE, ST_IACK_WAIT: begin
                bus_cycle = 1'b1;
                fc        = FC_CPU_SPACE;
                addr      = ack_addr;
            end
            ST_DONE: begin
                done        = 1'b1;
                done_vector = vec_q;
                done_kind   = kind_q;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/iack_sequencer_chk.sv
module iack_sequencer_chk #(
    parameter int ADDR_W = 24,
    parameter int VEC_W  = 8,
    parameter int SPURIOUS_VEC = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              boundary,
    input logic              resp_vec_valid,
    input logic [VEC_W-1:0]  resp_vec,
    input logic              resp_autovec,
    input logic              resp_buserr,
    input logic              stack_req,
    input logic              sr_enter_super,
    input logic              bus_cycle,
    input logic [2:0]        fc,
    input logic [ADDR_W-1:0] addr,
    input logic              done,
    input logic [VEC_W-1:0]  done_vector,
    input logic [1:0]        done_kind
);
    p_stack_after_boundary_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stack_req) |-> $past(boundary));

    p_super_in_stack_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sr_enter_super |-> stack_req ##1 (!stack_req && bus_cycle));

    p_cpu_space_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cycle |-> (fc == 3'b111) && addr[0] && (&addr[ADDR_W-1:4]) && (addr[3:1] != 3'd0));

    p_addr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cycle && $past(bus_cycle)) |-> $stable(addr));

    p_vector_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && done_kind == 2'b01) |-> (done_vector == $past(resp_vec)));

    p_spurious_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && done_kind == 2'b11) |-> (done_vector == VEC_W'(SPURIOUS_VEC)));

    p_done_cause_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(bus_cycle && (resp_buserr || resp_autovec || resp_vec_valid)));

    p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_kind_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> (done_kind == 2'b00));

endmodule

bind iack_sequencer iack_sequencer_chk #(
    .ADDR_W(ADDR_W), .VEC_W(VEC_W), .SPURIOUS_VEC(SPURIOUS_VEC)
) u_chk (.*);

// File: tb/tb_iack_sequencer.sv
module tb_iack_sequencer;
    localparam int CLK_PERIOD = 10;
    localparam int N_STACK = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] pend_level = '0;
    logic       boundary = 1'b0;
    logic       resp_vec_valid = 1'b0;
    logic [7:0] resp_vec = '0;
    logic       resp_autovec = 1'b0;
    logic       resp_buserr = 1'b0;
    logic        stack_req, sr_enter_super, bus_cycle, done;
    logic [2:0]  fc;
    logic [23:0] addr;
    logic [7:0]  done_vector;
    logic [1:0]  done_kind;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    iack_sequencer dut (
        .clk(clk), .rst_n(rst_n), .pend_level(pend_level), .boundary(boundary),
        .resp_vec_valid(resp_vec_valid), .resp_vec(resp_vec),
        .resp_autovec(resp_autovec), .resp_buserr(resp_buserr),
        .stack_req(stack_req), .sr_enter_super(sr_enter_super),
        .bus_cycle(bus_cycle), .fc(fc), .addr(addr), .done(done),
        .done_vector(done_vector), .done_kind(done_kind)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic t_reset();
        chk(stack_req == 0 && sr_enter_super == 0 && bus_cycle == 0, "R1 ctrl", {stack_req, sr_enter_super, bus_cycle}, 0);
        chk(fc == 0 && addr == 0, "R1 bus", addr, 0);
        chk(done == 0 && done_vector == 0 && done_kind == 0, "R1 done", {done, done_vector, done_kind}, 0);
    endtask

    task automatic t_level_zero();
        pend_level = 3'd0;
        for (int i = 0; i < 6; i++) begin
            boundary = 1'b1;
            @(negedge clk);
            chk(stack_req == 0 && bus_cycle == 0, "R2 level zero idle", {stack_req, bus_cycle}, 0);
        end
        boundary = 1'b0;
    endtask

    // One full sequence; bv/av/ve select the responses given in IACK_WAIT
    task automatic do_seq(input logic [2:0] lvl, input int wait_n, input logic [2:0] new_lvl,
                          input bit noise, input bit bv, input bit av, input bit ve,
                          input logic [7:0] vec, input logic [1:0] exp_kind,
                          input logic [7:0] exp_vec, input string tag);
        logic [23:0] exp_addr;
        exp_addr = {20'hFFFFF, lvl, 1'b1};
        pend_level = lvl;
        @(negedge clk);
        for (int i = 0; i < wait_n; i++) begin
            chk(stack_req == 0, "R3 wait for boundary", stack_req, 0);
            @(negedge clk);
        end
        pend_level = new_lvl;
        boundary = 1'b1;
        @(negedge clk);
        boundary = 1'b0;
        for (int i = 0; i < N_STACK; i++) begin
            chk(stack_req == 1 && bus_cycle == 0, "R3 stack window", {stack_req, bus_cycle}, 2'b10);
            chk(sr_enter_super == (i == N_STACK-1), "R4 status pulse", sr_enter_super, (i == N_STACK-1));
            @(negedge clk);
        end
        chk(stack_req == 0 && bus_cycle == 1, "R5 cycle after stack", {stack_req, bus_cycle}, 2'b01);
        chk(fc == 3'b111, "R5 fc", fc, 3'b111);
        chk(addr == exp_addr, "R6 R5 addr drive", addr, exp_addr);
        if (noise) resp_buserr = 1'b1;
        @(negedge clk);
        resp_buserr = 1'b0;
        chk(bus_cycle == 1 && done == 0, "R7 still waiting", {bus_cycle, done}, 2'b10);
        chk(addr == exp_addr, "R6 addr held", addr, exp_addr);
        resp_buserr = bv; resp_autovec = av; resp_vec_valid = ve; resp_vec = vec;
        @(negedge clk);
        resp_buserr = 0; resp_autovec = 0; resp_vec_valid = 0; resp_vec = '0;
        pend_level = 3'd0;
        chk(done == 1 && bus_cycle == 0, "R12 done due", {done, bus_cycle}, 2'b10);
        chk(done_kind == exp_kind, {tag, " kind"}, done_kind, exp_kind);
        chk(done_vector == exp_vec, {tag, " vector"}, done_vector, exp_vec);
        @(negedge clk);
        chk(done == 0 && done_kind == 0 && bus_cycle == 0, "R12 single pulse", {done, done_kind}, 0);
        @(negedge clk);
    endtask

    task automatic t_vector();   do_seq(3'd5, 0, 3'd5, 0, 0, 0, 1, 8'h40, 2'b01, 8'h40, "R8"); endtask
    task automatic t_autovec();  do_seq(3'd3, 3, 3'd3, 0, 0, 1, 0, 8'h00, 2'b10, 8'd27, "R9"); endtask
    task automatic t_buserr();   do_seq(3'd7, 1, 3'd7, 0, 1, 0, 0, 8'h00, 2'b11, 8'd24, "R10"); endtask
    task automatic t_priority();
        do_seq(3'd2, 0, 3'd2, 0, 1, 1, 1, 8'h55, 2'b11, 8'd24, "R11 buserr wins");
        do_seq(3'd6, 0, 3'd6, 0, 0, 1, 1, 8'h55, 2'b10, 8'd30, "R11 autovec wins");
    endtask
    task automatic t_latch();    do_seq(3'd1, 2, 3'd6, 0, 0, 1, 0, 8'h00, 2'b10, 8'd25, "R6 latched level"); endtask
    task automatic t_noise();    do_seq(3'd4, 0, 3'd4, 1, 0, 0, 1, 8'h81, 2'b01, 8'h81, "R7 early response ignored"); endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_level_zero();
        t_vector();
        t_autovec();
        t_buserr();
        t_priority();
        t_latch();
        t_noise();
        t_level_zero();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL R12 watchdog expired actual=0x0 expected=0x1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule